// File: doc/BRIEF.md
# Predicated Result Write-Back Controller

This block steps through the elements of a short vector, one element per clock, after a single start pulse. For each element it adds two source operands, derives a four-bit condition field from the signed sum, and then decides what to store: the sum, the condition field, both, or neither. The decision combines three things: the element's predicate mask bit, a single-bit test on the condition field, and an optional zeroing mode. The zeroing mode writes zero in place of any result that would otherwise be skipped.

The destination is modelled as two register arrays, one for results and one for condition fields. Each array has a one-hot write-enable pulse that shows which element was written in a given cycle. An element that gets no write keeps its earlier contents. Sources and configuration are captured when a start is accepted. Elements run in ascending order from 0 to the effective vector length minus one. The vector length is never shortened by a failing test, and a done pulse marks the end of the run.

Top module: `predResultSeq`

## Requirements
- R1: Each element's result is the sum of its two operands modulo 2^DATA_W. Its condition field is {lt, gt, eq, so} at bit positions 3, 2, 1, 0. The sum is read as signed: lt is the sign bit, gt means positive and non-zero, eq means zero, and so is always 0.
- R2: An element whose predicate bit is 0 stores nothing when zeroing is off. Neither of its write enables rises, and both of its array entries keep their old values.
- R3: The condition field of an unmasked element is written exactly when rcEn or cmpOnly is 1, whether the test passes or fails.
- R4: With rcEn=1, condSel picks the tested bit (0=lt, 1=gt, 2=eq, 3=so). The result of an unmasked element is stored only when that bit differs from invTest.
- R5: With rcEn=0, the tested bit is eq. The result is stored only when eq differs from invTest.
- R6: With cmpOnly=1, no result is ever written, including zeros. Condition fields are still written for unmasked elements.
- R7: With zeroDst=1 and cmpOnly=0, every element that fails its test or is masked out gets 0 written as its result, and its result write enable pulses.
- R8: The writes for element k appear on the outputs k+1 cycles after the start is accepted, in ascending order, with at most one result enable and one condition enable high per cycle. done is a one-cycle pulse in the same cycle as the last element's writes. For an effective length of zero, done pulses in the cycle right after the start.
- R9: startReq is ignored while busy is high. A request made during a run changes neither its length nor its data.
- R10: A vecLen above MAX_VL is treated as MAX_VL.
- R11: After reset, busy, done and all write enables are 0, and both arrays hold zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rstN | input | 1 | active-low asynchronous reset |
| startReq | input | 1 | start request, accepted only when idle |
| vecLen | input | $clog2(MAX_VL+1) | vector length for the run |
| predMask | input | MAX_VL | predicate mask, bit i for element i |
| rcEn | input | 1 | store condition fields and test the selected bit |
| cmpOnly | input | 1 | compare-only: store condition fields, never results |
| invTest | input | 1 | value of the tested bit that cancels the result |
| condSel | input | 2 | selected condition bit when rcEn=1 |
| zeroDst | input | 1 | write zero for failed or masked elements |
| srcA | input | MAX_VL*DATA_W | first operand array, element i at bits i*DATA_W |
| srcB | input | MAX_VL*DATA_W | second operand array |
| resArr | output | MAX_VL*DATA_W | result array contents |
| resWe | output | MAX_VL | one-hot result write pulse |
| condArr | output | MAX_VL*4 | condition field array, element i at bits i*4 |
| condWe | output | MAX_VL | one-hot condition write pulse |
| busy | output | 1 | a run is in progress |
| done | output | 1 | end-of-run pulse |

## Verification
Two pairs of events can coincide in one cycle. The first is a condition-field store together with a cancelled or zeroed result store for the same element. The second is the last element's writes together with the done pulse. The bench sweeps every combination of rcEn, cmpOnly, invTest, condSel and zeroDst over several masks and over operands that give negative, positive and zero sums, so failed tests with Rc set and zeroing on are hit many times. In every cycle it compares both enable vectors and done against a cycle-exact model. After each run it compares both arrays in full, and this also shows that skipped elements kept their contents from earlier runs.

// File: rtl/predWbPkg.sv
package predWbPkg;
  localparam int CondW = 4;
  localparam int CondLt = 3;
  localparam int CondGt = 2;
  localparam int CondEq = 1;
  localparam int CondSo = 0;

  typedef struct packed {
    logic loadCfg;
    logic stepEl;
  } wbStrobe_t;

  typedef struct packed {
    logic       rcEn;
    logic       cmpOnly;
    logic       invTest;
    logic [1:0] condSel;
    logic       zeroDst;
  } wbCfg_t;

  typedef enum logic [1:0] {stIdle, stRun, stFin} wbState_t;
endpackage

// File: rtl/predWbEval.sv
module predWbEval
  import predWbPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              predBit,
  input  wbCfg_t            cfg,
  output logic [DATA_W-1:0] resVal,
  output logic              resWr,
  output logic [CondW-1:0]  condVal,
  output logic              condWr
);
  logic [DATA_W-1:0] sum;
  logic isNeg, isZero, testBit, pass;

  always_comb begin
    sum    = opA + opB;
    isNeg  = sum[DATA_W-1];
    isZero = (sum == '0);
    condVal = '0;
    condVal[CondLt] = isNeg;
    condVal[CondGt] = !isNeg && !isZero;
    condVal[CondEq] = isZero;
    condVal[CondSo] = 1'b0;
    if (cfg.rcEn) begin
      case (cfg.condSel)
        2'd0:    testBit = condVal[CondLt];
        2'd1:    testBit = condVal[CondGt];
        2'd2:    testBit = condVal[CondEq];
        default: testBit = condVal[CondSo];
      endcase
    end else begin
      testBit = condVal[CondEq];
    end
    pass   = testBit ^ cfg.invTest;
    resVal = '0;
    resWr  = 1'b0;
    condWr = predBit && (cfg.rcEn || cfg.cmpOnly);
    if (!cfg.cmpOnly) begin
      if (predBit && pass) begin
        resVal = sum;
        resWr  = 1'b1;
      end else if (cfg.zeroDst) begin
        resWr = 1'b1;
      end
    end
  end
endmodule

// File: rtl/predWbCtrl.sv
module predWbCtrl
  import predWbPkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int VLW    = 4,
  parameter int IDXW   = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic [VLW-1:0]  vecLen,
  output wbStrobe_t       strobe,
  output logic [IDXW-1:0] elIdx,
  output logic            busy,
  output logic            done
);
  localparam logic [VLW-1:0] VlCap = VLW'(MAX_VL);

  wbState_t        state;
  logic [IDXW-1:0] lastIdx;
  logic [VLW-1:0]  vlEff, vlLast;
  logic            accept;

  assign vlEff  = (vecLen > VlCap) ? VlCap : vecLen;
  assign vlLast = vlEff - 1'b1;
  assign accept = (state == stIdle) && startReq;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= stIdle;
      elIdx   <= '0;
      lastIdx <= '0;
    end else begin
      case (state)
        stIdle: if (accept) begin
          elIdx   <= '0;
          lastIdx <= vlLast[IDXW-1:0];
          state   <= (vlEff == '0) ? stFin : stRun;
        end
        stRun: begin
          if (elIdx == lastIdx) state <= stFin;
          else elIdx <= elIdx + 1'b1;
        end
        default: state <= stIdle;
      endcase
    end
  end

  always_comb begin
    strobe.loadCfg = accept;
    strobe.stepEl  = (state == stRun);
    busy = (state != stIdle);
    done = (state == stFin);
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_idx_order_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == stRun && elIdx != lastIdx) |=> (state == stRun && elIdx == IDXW'($past(elIdx) + 1'b1)));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq) |=> $stable(lastIdx));
endmodule

// File: rtl/predWbData.sv
module predWbData
  import predWbPkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int DATA_W = 8,
  parameter int IDXW   = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  wbStrobe_t                strobe,
  input  logic [IDXW-1:0]          elIdx,
  input  wbCfg_t                   cfgIn,
  input  logic [MAX_VL-1:0]        predMask,
  input  logic [MAX_VL*DATA_W-1:0] srcA,
  input  logic [MAX_VL*DATA_W-1:0] srcB,
  output logic [MAX_VL*DATA_W-1:0] resArr,
  output logic [MAX_VL-1:0]        resWe,
  output logic [MAX_VL*CondW-1:0]  condArr,
  output logic [MAX_VL-1:0]        condWe
);
  wbCfg_t                   cfgQ;
  logic [MAX_VL-1:0]        predQ;
  logic [MAX_VL*DATA_W-1:0] aQ, bQ;
  logic [DATA_W-1:0]        curA, curB, evRes;
  logic [CondW-1:0]         evCond;
  logic                     evResWr, evCondWr;
  logic [MAX_VL-1:0]        selHot;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ  <= '0;
      predQ <= '0;
      aQ    <= '0;
      bQ    <= '0;
    end else if (strobe.loadCfg) begin
      cfgQ  <= cfgIn;
      predQ <= predMask;
      aQ    <= srcA;
      bQ    <= srcB;
    end
  end

  assign curA   = aQ[elIdx*DATA_W +: DATA_W];
  assign curB   = bQ[elIdx*DATA_W +: DATA_W];
  assign selHot = MAX_VL'(1) << elIdx;

  predWbEval #(.DATA_W(DATA_W)) uEval (
    .opA(curA), .opB(curB), .predBit(predQ[elIdx]), .cfg(cfgQ),
    .resVal(evRes), .resWr(evResWr), .condVal(evCond), .condWr(evCondWr)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resWe  <= '0;
      condWe <= '0;
    end else begin
      resWe  <= (strobe.stepEl && evResWr)  ? selHot : '0;
      condWe <= (strobe.stepEl && evCondWr) ? selHot : '0;
    end
  end

  for (genvar g = 0; g < MAX_VL; g++) begin : gSlot
    logic [DATA_W-1:0] resSlot;
    logic [CondW-1:0]  condSlot;
    logic              hit;
    assign hit = strobe.stepEl && (elIdx == IDXW'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resSlot  <= '0;
        condSlot <= '0;
      end else begin
        if (hit && evResWr)  resSlot  <= evRes;
        if (hit && evCondWr) condSlot <= evCond;
      end
    end
    assign resArr[g*DATA_W +: DATA_W] = resSlot;
    assign condArr[g*CondW +: CondW]  = condSlot;

    assert_masked_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
      (resWe[g] && !predQ[g]) |-> (resSlot == '0));
    assert_zero_only_masked_R7: assert property (@(posedge clk) disable iff (!rstN)
      (resWe[g] && !cfgQ.zeroDst) |-> predQ[g]);
  end

  assert_cmp_nores_R6: assert property (@(posedge clk) disable iff (!rstN)
    cfgQ.cmpOnly |-> (resWe == '0));
  assert_cond_gate_R3: assert property (@(posedge clk) disable iff (!rstN)
    (condWe != '0) |-> (cfgQ.rcEn || cfgQ.cmpOnly));
  assert_we_onehot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(resWe) && $onehot0(condWe));
endmodule

// File: rtl/predResultSeq.sv
module predResultSeq
  import predWbPkg::*;
#(
  parameter int MAX_VL = 8,
  parameter int DATA_W = 8,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startReq,
  input  logic [VLW-1:0]           vecLen,
  input  logic [MAX_VL-1:0]        predMask,
  input  logic                     rcEn,
  input  logic                     cmpOnly,
  input  logic                     invTest,
  input  logic [1:0]               condSel,
  input  logic                     zeroDst,
  input  logic [MAX_VL*DATA_W-1:0] srcA,
  input  logic [MAX_VL*DATA_W-1:0] srcB,
  output logic [MAX_VL*DATA_W-1:0] resArr,
  output logic [MAX_VL-1:0]        resWe,
  output logic [MAX_VL*4-1:0]      condArr,
  output logic [MAX_VL-1:0]        condWe,
  output logic                     busy,
  output logic                     done
);
  wbStrobe_t       strobe;
  logic [IDXW-1:0] elIdx;
  wbCfg_t          cfgIn;

  assign cfgIn = '{rcEn: rcEn, cmpOnly: cmpOnly, invTest: invTest,
                   condSel: condSel, zeroDst: zeroDst};

  predWbCtrl #(.MAX_VL(MAX_VL), .VLW(VLW), .IDXW(IDXW)) uCtrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .vecLen(vecLen),
    .strobe(strobe), .elIdx(elIdx), .busy(busy), .done(done)
  );

  predWbData #(.MAX_VL(MAX_VL), .DATA_W(DATA_W), .IDXW(IDXW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .elIdx(elIdx), .cfgIn(cfgIn),
    .predMask(predMask), .srcA(srcA), .srcB(srcB),
    .resArr(resArr), .resWe(resWe), .condArr(condArr), .condWe(condWe)
  );
endmodule

// File: tb/sim_predResultSeq.sv
module sim_predResultSeq;
  localparam int MV = 8;
  localparam int DW = 8;
  localparam int VLW = 4;

  logic clk = 0, rstN = 0, startReq = 0;
  logic [VLW-1:0] vecLen = '0;
  logic [MV-1:0] predMask = '0;
  logic rcEn = 0, cmpOnly = 0, invTest = 0, zeroDst = 0;
  logic [1:0] condSel = '0;
  logic [MV*DW-1:0] srcA = '0, srcB = '0, resArr;
  logic [MV-1:0] resWe, condWe;
  logic [MV*4-1:0] condArr;
  logic busy, done;

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [DW-1:0] expRes [MV];
  logic [3:0]    expCond[MV];

  always #5 clk = ~clk;

  predResultSeq #(.MAX_VL(MV), .DATA_W(DW)) u0 (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic runOp(input int vl, input logic [MV-1:0] mask, input bit rc,
                       input bit c1, input bit inv, input logic [1:0] sel,
                       input bit zr, input int pat, input bit midStart);
    int vlEff;
    logic [MV-1:0] ewr, ecw;
    logic [DW-1:0] eval[MV];
    logic [3:0] econd[MV];
    string tag;
    vlEff = (vl > MV) ? MV : vl;
    tag = c1 ? "R6" : (zr ? "R7" : (rc ? "R4" : "R5"));
    ewr = '0; ecw = '0;
    @(negedge clk);
    for (int i = 0; i < MV; i++) begin
      logic [DW-1:0] a, b, s;
      bit lt, eq, gt, tb, pass;
      a = DW'(cfgMix(pat) * 29 + i * 71 + pat * 13);
      b = (((i + pat + cfgMix(pat)) % 3) == 0) ? DW'(-a) : DW'(i * 45 + pat * 7 + 3);
      srcA[i*DW +: DW] = a;
      srcB[i*DW +: DW] = b;
      s = a + b;
      lt = s[DW-1]; eq = (s == 0); gt = !lt && !eq;
      econd[i] = {lt, gt, eq, 1'b0};
      tb = rc ? (sel == 0 ? lt : sel == 1 ? gt : sel == 2 ? eq : 1'b0) : eq;
      pass = tb != inv;
      eval[i] = 0;
      if (i < vlEff) begin
        ecw[i] = mask[i] && (rc || c1);
        if (!c1) begin
          if (mask[i] && pass) begin ewr[i] = 1; eval[i] = s; end
          else if (zr) ewr[i] = 1;
        end
      end
    end
    vecLen = VLW'(vl); predMask = mask; rcEn = rc; cmpOnly = c1;
    invTest = inv; condSel = sel; zeroDst = zr; startReq = 1;
    @(posedge clk); @(negedge clk);
    startReq = 0;
    for (int cyc = 0; cyc <= vlEff + 1; cyc++) begin
      logic [MV-1:0] xr, xc;
      if (cyc > 0) begin @(posedge clk); @(negedge clk); end
      if (midStart && cyc == 1) begin
        startReq = 1; vecLen = 4'd2; predMask = ~mask; srcA = ~srcA; // R9 ignored
      end else startReq = 0;
      xr = '0; xc = '0;
      if (cyc >= 1 && cyc <= vlEff) begin
        xr[cyc-1] = ewr[cyc-1];
        xc[cyc-1] = ecw[cyc-1];
      end
      chk(resWe == xr, tag, "resWe (R8 timing)", resWe, xr);
      chk(condWe == xc, "R3", "condWe", condWe, xc);
      chk(done == (cyc == vlEff), "R8", "done", done, cyc == vlEff);
    end
    chk(busy == 0, "R9", "busy after run", busy, 0);
    for (int i = 0; i < MV; i++) begin
      if (ewr[i]) expRes[i] = eval[i];
      if (ecw[i]) expCond[i] = econd[i];
    end
    for (int i = 0; i < MV; i++) begin
      chk(resArr[i*DW +: DW] == expRes[i], (mask[i] || zr) ? tag : "R2",
          $sformatf("res[%0d] R1", i), resArr[i*DW +: DW], expRes[i]);
      chk(condArr[i*4 +: 4] == expCond[i], "R1", $sformatf("cond[%0d] R3", i),
          condArr[i*4 +: 4], expCond[i]);
    end
  endtask

  int curCfg = 0;
  function automatic int cfgMix(input int pat);
    return curCfg + pat;
  endfunction

  initial begin
    for (int i = 0; i < MV; i++) begin expRes[i] = 0; expCond[i] = 0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 0 && done == 0, "R11", "busy/done", {busy, done}, 0);
    chk(resWe == 0 && condWe == 0, "R11", "enables", {resWe, condWe}, 0);
    chk(resArr == 0 && condArr == 0, "R11", "arrays", resArr, 0);
    rstN = 1;
    for (int c = 0; c < 64; c++) begin
      curCfg = c;
      for (int p = 0; p < 3; p++) begin
        logic [MV-1:0] m;
        int vl;
        m = (p == 0) ? 8'hFF : (p == 1) ? (8'hA5 ^ 8'(c)) : {c[2:0], 5'(c)};
        vl = (c + p * 3) % 10;  // R10: 9 exceeds MAX_VL
        runOp(vl, m, c[0], c[1], c[2], c[4:3], c[5], p, (p == 1) && vl >= 3);
      end
    end
    curCfg = 5;
    runOp(15, 8'h5A, 1, 0, 0, 2'd0, 1, 2, 0);  // R10 clamp
    runOp(0, 8'hFF, 1, 0, 0, 2'd2, 1, 0, 0);   // R8 empty run
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule